// File: doc/BRIEF.md
# Addressable LED Pulse Transmitter

This block drives a single-wire chain of addressable LEDs. Software writes words into a small transmit queue. The block sends each queued word one bit at a time, most significant bit first. Every bit is a high pulse followed by a low stretch, and together they fill a fixed bit period. The total period, the high time for a zero and the high time for a one are all counted in ticks of a selectable prescaled clock. A word can be 24 or 32 bits long.

A strobe setting turns the next data write into a latch command. The command is tagged in the queue with that setting. When the engine reaches it, the line is held low for a long fixed interval, so that the LEDs in the chain latch their colours, and then the engine goes on with the next entry.

The register side has two write targets, a control word and a data word. One registered status word reflects the configuration and the queue flags. A level-sensitive interrupt reports the queue level.

Top module: `led_pulse_tx`

## Requirements
- R1: A control write stores enable (bit 0), word length (bit 1: 0 = 24-bit, 1 = 32-bit), strobe (bit 2), prescaler select (bits 5:3), bit-period ticks (bits 14:10), zero high ticks (bits 19:15), one high ticks (bits 24:20) and interrupt mode (bit 27). `status_o` reads these back at the same positions, shows log2 of the queue depth in bits 9:6 and reads zero in bits 26:25.
- R2: A 32-bit word is sent from bit 31 down to bit 0. A 24-bit word is sent from bit 23 down to bit 0, and its top byte is never sent. The word length is taken at the moment the engine takes the word.
- R3: One tick lasts 2^(select+1) clock cycles. A one bit is high for the one-high tick count and a zero bit is high for the zero-high tick count. Successive bits of a word start exactly one bit period (bit-period ticks) apart.
- R4: The queue returns words in write order and holds DEPTH entries (4 by default). A data write while the queue is full is dropped.
- R5: A data write made while strobe is 1 queues a latch command. The command sends no pulses and holds the line low for 127 bit periods. Entries written before and after it are sent normally.
- R6: Busy (status bit 31) is 1 while the queue is non-empty or a word or command is in progress. It stays 1 until the final low stretch of the last bit has ended.
- R7: The interrupt requires enable. With interrupt mode 0 it is 1 while the queue holds fewer than DEPTH/2 entries. With interrupt mode 1 it is 1 only while the queue is empty.
- R8: While enable is 0, the line stays low, no entry leaves the queue and the interrupt is 0.
- R9: The status bits report queue empty (bit 28), at least half full (bit 29) and full (bit 30).
- R10: After reset, the configuration is all zero, the queue is empty, the line and the interrupt are low, and `status_o` reads 0x10000080 with the default depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_sel | input | 1 | Write target: 0 = control word, 1 = data word |
| bus_wdata | input | 32 | Write data |
| status_o | output | 32 | Registered control and status readback |
| led_o | output | 1 | Serial line to the LED chain |
| irq_o | output | 1 | Queue-level interrupt |

## Verification
Two things can fall in the same cycle: a data write that pushes into the queue, and the engine taking the head entry on a tick edge. The bench provokes this by writing several words and a latch command back to back while earlier words are still being sent, so some pushes meet pops. It judges the result by decoding the pulses on the line, one bit from each pulse width. Every decoded word is compared in order against a scoreboard of the words written, and the low gap around the latch command is measured to the exact cycle.

// File: rtl/led_pkg.sv
package led_pkg;
  typedef struct packed {
    logic        is_reset;
    logic [31:0] word;
  } led_item_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BIT,
    ST_RST
  } eng_state_t;
endpackage

// File: rtl/led_fifo.sv
module led_fifo
  import led_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  led_item_t                  din,
  input  logic                       pop,
  output led_item_t                  dout,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $bits(led_item_t);

  logic [IW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  assign dout = led_item_t'(mem[rp]);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      level <= level + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));
endmodule

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = 2 ** SEL_W;

  logic [CW-1:0] cnt;
  logic [CW-1:0] mask;

  assign mask = (CW'(2) << sel) - CW'(1);
  assign tick = en && ((cnt & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  // shortest tick spacing is two clocks
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/led_bit_engine.sv
module led_bit_engine
  import led_pkg::*;
#(
  parameter int RESET_BITS = 127,
  parameter int TW         = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          mode32,
  input  logic [TW-1:0] t_tot,
  input  logic [TW-1:0] t_zero,
  input  logic [TW-1:0] t_one,
  input  logic          fifo_empty,
  input  led_item_t     head,
  output logic          pop,
  output logic          led_o,
  output logic          active
);
  localparam int MAXC = (RESET_BITS > 32) ? RESET_BITS : 32;
  localparam int CW   = $clog2(MAXC);

  eng_state_t    state;
  logic [31:0]   shreg;
  logic [CW-1:0] left;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] thigh;
  logic          last_tick;

  assign pop       = en && tick && (state == ST_IDLE) && !fifo_empty;
  assign thigh     = shreg[31] ? t_one : t_zero;
  assign last_tick = (tcnt == t_tot - TW'(1));
  assign active    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      tcnt  <= '0;
      left  <= '0;
      shreg <= '0;
      led_o <= 1'b0;
    end else begin
      led_o <= (state == ST_BIT) && (tcnt < thigh);
      unique case (state)
        ST_IDLE: begin
          if (pop) begin
            tcnt <= '0;
            if (head.is_reset) begin
              state <= ST_RST;
              left  <= CW'(RESET_BITS - 1);
            end else begin
              state <= ST_BIT;
              left  <= mode32 ? CW'(31) : CW'(23);
              shreg <= mode32 ? head.word : {head.word[23:0], 8'h00};
            end
          end
        end
        default: begin
          if (tick) begin
            if (last_tick) begin
              tcnt <= '0;
              if (left == '0) begin
                state <= ST_IDLE;
              end else begin
                left  <= left - 1'b1;
                shreg <= {shreg[30:0], 1'b0};
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_line_low_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !led_o);

  assert_pulse_in_word_R6: assert property (@(posedge clk) disable iff (rst)
    led_o |-> $past(active));
endmodule

// File: rtl/led_pulse_tx.sv
module led_pulse_tx
  import led_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int RESET_BITS = 127
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic        bus_sel,
  input  logic [31:0] bus_wdata,
  output logic [31:0] status_o,
  output logic        led_o,
  output logic        irq_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int TW = 5;

  logic          en_q, mode_q, strobe_q, irqsel_q;
  logic [2:0]    sel_q;
  logic [TW-1:0] tot_q, th0_q, th1_q;

  logic          tick, pop, push, active, busy;
  logic          empty, half, full;
  logic [AW:0]   level;
  led_item_t     head, din;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; mode_q <= 1'b0; strobe_q <= 1'b0; irqsel_q <= 1'b0;
      sel_q <= '0; tot_q <= '0; th0_q <= '0; th1_q <= '0;
    end else if (bus_we && !bus_sel) begin
      en_q     <= bus_wdata[0];
      mode_q   <= bus_wdata[1];
      strobe_q <= bus_wdata[2];
      sel_q    <= bus_wdata[5:3];
      tot_q    <= bus_wdata[14:10];
      th0_q    <= bus_wdata[19:15];
      th1_q    <= bus_wdata[24:20];
      irqsel_q <= bus_wdata[27];
    end
  end

  assign empty = (level == '0);
  assign full  = (level == (AW+1)'(DEPTH));
  assign half  = (level >= (AW+1)'(DEPTH / 2));
  assign push  = bus_we && bus_sel && !full;
  assign din   = '{is_reset: strobe_q, word: bus_wdata};
  assign busy  = active || !empty;

  led_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(din),
    .pop(pop), .dout(head), .level(level)
  );

  led_tick_gen #(.SEL_W(3)) u_tick (
    .clk(clk), .rst(rst), .en(en_q), .sel(sel_q), .tick(tick)
  );

  led_bit_engine #(.RESET_BITS(RESET_BITS), .TW(TW)) u_eng (
    .clk(clk), .rst(rst), .en(en_q), .tick(tick), .mode32(mode_q),
    .t_tot(tot_q), .t_zero(th0_q), .t_one(th1_q),
    .fifo_empty(empty), .head(head), .pop(pop), .led_o(led_o), .active(active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= {busy, full, half, empty, irqsel_q, 2'b00,
                   th1_q, th0_q, tot_q, 4'(AW), sel_q, strobe_q, mode_q, en_q};
      irq_o    <= en_q && (irqsel_q ? empty : (level < (AW+1)'(DEPTH / 2)));
    end
  end

  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_sel && full) |=> (level <= $past(level)));

  assert_irq_empty_mode_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_o && $past(irqsel_q)) |-> $past(empty));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(en_q));
endmodule

// File: tb/led_pulse_tx_tb.sv
`timescale 1ns/1ps
module led_pulse_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_sel = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] status_o;
  logic        led_o, irq_o;

  always #5 clk = ~clk;

  led_pulse_tx u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .status_o(status_o), .led_o(led_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] data;
    int len; int div; int th0; int th1; int tot; int gap;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0, words_seen = 0;
  int cur_div = 2, cur_th0 = 3, cur_th1 = 7, cur_tot = 10, cur_len = 32;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit en, bit m32, bit strb, int sel,
                                         int tot, int th0, int th1, bit isel);
    return {4'b0, isel, 2'b0, th1[4:0], th0[4:0], tot[4:0], 4'b0,
            sel[2:0], strb, m32, en};
  endfunction

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] d, input int gap);
    exp_t e;
    e.data = d; e.len = cur_len; e.div = cur_div; e.th0 = cur_th0;
    e.th1 = cur_th1; e.tot = cur_tot; e.gap = gap;
    exp_q.push_back(e);
    wr(1'b1, d);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (status_o[31] && n < 20000) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R4 all queued words seen", exp_q.size(), 0);
  endtask

  // monitor: decode pulses and compare against the scoreboard
  int hi_len, lo_len, since_rise, bit_idx;
  logic [31:0] acc;
  logic prev;
  always @(negedge clk) begin
    if (rst) begin
      prev = 1'b0; hi_len = 0; lo_len = 0; since_rise = 0; bit_idx = 0; acc = '0;
    end else begin
      if (led_o && !prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 pulse with nothing expected", 1, 0);
        end else begin
          if (bit_idx == 0 && exp_q[0].gap != 0)
            chk(lo_len == exp_q[0].gap, "R5 latch low gap", lo_len, exp_q[0].gap);
          if (bit_idx > 0)
            chk(since_rise == exp_q[0].tot * exp_q[0].div, "R3 bit period",
                since_rise, exp_q[0].tot * exp_q[0].div);
        end
        since_rise = 0; hi_len = 0;
      end
      if (!led_o && prev) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          bit b;
          logic [31:0] m;
          e = exp_q[0];
          b = (hi_len == e.th1 * e.div);
          chk(b || hi_len == e.th0 * e.div, "R3 high time", hi_len, e.th0 * e.div);
          acc = {acc[30:0], b};
          bit_idx++;
          if (bit_idx == e.len) begin
            m = (e.len == 32) ? 32'hFFFF_FFFF : ((32'd1 << e.len) - 32'd1);
            chk((acc & m) == (e.data & m), "R2 decoded word", acc & m, e.data & m);
            void'(exp_q.pop_front());
            bit_idx = 0; acc = '0; words_seen++;
          end
        end
        lo_len = 0;
      end
      if (led_o) hi_len++; else lo_len++;
      since_rise++;
      prev = led_o;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int ws, falls, n;
    logic pl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R10 reset state
    chk(status_o == 32'h1000_0080, "R10 reset status", status_o, 32'h1000_0080);
    chk(!led_o && !irq_o, "R10 line and irq low", {led_o, irq_o}, 0);

    // R1 readback with enable off
    wr(1'b0, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk);
    chk(status_o == 32'h19FF_FCBE, "R1 control readback", status_o, 32'h19FF_FCBE);
    chk(!irq_o, "R8 irq low while disabled", irq_o, 0);

    // R2 R3: 32-bit words streamed back to back (pushes meet pops)
    cur_div = 2; cur_len = 32;
    wr(1'b0, mk_cfg(1, 1, 0, 0, 10, 3, 7, 0));
    ws = words_seen;
    send(32'hC3A5_0F01, 0);
    send(32'h8000_0001, 0);
    send(32'h7FFF_FFFE, 0);
    send(32'h1234_5678, 0);
    send(32'hFFFF_0000, 0);
    wait_idle();
    chk(words_seen - ws == 5, "R4 word count in order", words_seen - ws, 5);

    // R2 24-bit mode drops the top byte
    cur_len = 24;
    wr(1'b0, mk_cfg(1, 0, 0, 0, 10, 3, 7, 0));
    send(32'hFFA5_C396, 0);
    wait_idle();

    // R3 prescaler select 1 gives 4-clock ticks, other timings
    cur_len = 32; cur_div = 4; cur_th0 = 2; cur_th1 = 5; cur_tot = 8;
    wr(1'b0, mk_cfg(1, 1, 0, 1, 8, 2, 5, 0));
    send(32'hA5A5_5A5A, 0);
    wait_idle();

    // R5 latch command between two words, tag captured at write time
    cur_div = 2; cur_th0 = 3; cur_th1 = 7; cur_tot = 10;
    wr(1'b0, mk_cfg(1, 1, 0, 0, 10, 3, 7, 0));
    send(32'h0000_0001, 0);
    wr(1'b0, mk_cfg(1, 1, 1, 0, 10, 3, 7, 0));
    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b0, mk_cfg(1, 1, 0, 0, 10, 3, 7, 0));
    send(32'h5555_AAAA, (10 - 7) * 2 + 2 + 127 * 10 * 2 + 2);
    wait_idle();

    // R6 busy holds through the final low stretch
    cur_len = 24;
    wr(1'b0, mk_cfg(1, 0, 0, 0, 10, 3, 7, 0));
    send(32'h0000_0000, 0);
    falls = 0; pl = led_o;
    while (falls < 24) begin
      @(negedge clk);
      if (pl && !led_o) falls++;
      pl = led_o;
    end
    n = 0;
    while (status_o[31] && n < 1000) begin @(negedge clk); n++; end
    chk(n == (10 - 3) * 2, "R6 busy tail length", n, (10 - 3) * 2);

    // R7 R9 interrupt modes and level flags, slow ticks keep entries queued
    wr(1'b0, mk_cfg(0, 1, 0, 0, 10, 3, 7, 0));
    wr(1'b0, mk_cfg(1, 1, 0, 7, 10, 3, 7, 0));
    repeat (2) @(negedge clk);
    chk(irq_o, "R7 mode0 irq when empty", irq_o, 1);
    wr(1'b1, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    chk(irq_o, "R7 mode0 irq below half", irq_o, 1);
    chk(status_o[30:28] == 3'b000, "R9 flags one entry", status_o[30:28], 0);
    wr(1'b1, 32'h0BAD_F00D);
    repeat (2) @(negedge clk);
    chk(!irq_o, "R7 mode0 irq off at half", irq_o, 0);
    chk(status_o[30:28] == 3'b010, "R9 flags half", status_o[30:28], 3'b010);
    wr(1'b0, mk_cfg(1, 1, 0, 7, 10, 3, 7, 1));
    repeat (2) @(negedge clk);
    chk(!irq_o, "R7 mode1 irq off when not empty", irq_o, 0);
    wr(1'b0, mk_cfg(0, 1, 0, 7, 10, 3, 7, 1));
    repeat (2) @(negedge clk);
    chk(!irq_o, "R8 irq off when disabled", irq_o, 0);

    // R4 R8 R9: fill while disabled, fifth write dropped, line stays low
    cur_len = 32; cur_div = 2;
    exp_q.push_back('{data: 32'hDEAD_BEEF, len: 32, div: 2, th0: 3, th1: 7, tot: 10, gap: 0});
    exp_q.push_back('{data: 32'h0BAD_F00D, len: 32, div: 2, th0: 3, th1: 7, tot: 10, gap: 0});
    send(32'h1111_0001, 0);
    send(32'h2222_0002, 0);
    wr(1'b1, 32'h3333_0003);
    repeat (2) @(negedge clk);
    chk(status_o[31:28] == 4'b1110, "R9 full flags", status_o[31:28], 4'b1110);
    n = 0;
    repeat (200) begin @(negedge clk); if (led_o) n++; end
    chk(n == 0, "R8 line low while disabled", n, 0);
    ws = words_seen;
    wr(1'b0, mk_cfg(1, 1, 0, 0, 10, 3, 7, 1));
    wait_idle();
    chk(words_seen - ws == 4, "R4 dropped write absent", words_seen - ws, 4);
    repeat (2) @(negedge clk);
    chk(irq_o, "R7 mode1 irq when empty", irq_o, 1);
    chk(status_o[31:28] == 4'b0001, "R9 empty after drain", status_o[31:28], 4'b0001);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule